// File: doc/BRIEF.md
# Core Power Switch Ramp Sequencer

This block produces the 8-bit clamp control word for the power switch of a single CPU core. Bit 0 is the rightmost bit of the word, and a set bit keeps that part of the switch clamped. A value of 0xFF means the switch is fully shut. A value of 0x00 means it is fully open.

To limit inrush current, the switch is opened in stages. Each stage holds a fixed code for a dwell measured in pulses of an external one-microsecond tick. Closing is a single write of 0xFF, followed by one dwell. The block reads back its own clamp word. If the switch is already fully open, an open request completes at once and nothing is rewritten.

The caller raises a request for one cycle. It then waits for `done`, or it watches `busy`.

Top module: `pwr_clamp_ramp`

## Requirements
- R1: When `rstN` is low, the block returns to its reset state: `clampWord` = 0xFF, `busy` = 0 and `done` = 0. This applies at power-up and also in the middle of a sequence.
- R2: An accepted open request drives `clampWord` through 0xFF, 0xFE, 0xF8, 0xF0 and 0x00, strictly in that order.
- R3: Each clamp code, including the final 0x00 of an open, is held for exactly `DWELL_TICKS` pulses of `usTick` (default 10). Clock cycles in which `usTick` is low never advance the sequence.
- R4: If `clampWord` is 0x00 when an open request arrives while idle, `done` rises in the next cycle. In that case `busy` stays low and `clampWord` does not change.
- R5: An accepted close request sets `clampWord` to 0xFF in the next cycle. It then holds that value for `DWELL_TICKS` tick pulses before `done`.
- R6: Requests that arrive while `busy` is high are ignored. The running sequence continues unchanged.
- R7: If open and close are both requested in the same idle cycle, the close is performed.
- R8: `done` is high for exactly one clock per finished sequence. It rises in the same cycle that `busy` falls.
- R9: `busy` goes high in the cycle after an accepted (non-skipped) request. It stays high until the sequence finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| openReq | input | 1 | Request to open the switch in stages |
| closeReq | input | 1 | Request to shut the switch |
| usTick | input | 1 | One-cycle pulse every microsecond |
| clampWord | output | 8 | Clamp control word for the power switch |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence ends |

## Verification
A step index or clamp register holding a wrong value would show up as an out-of-order or repeated code on `clampWord`. That error would be visible in the first cycle after the faulty step change. A dwell counter that is off by one moves a code change one tick pulse early or late. The bench catches this because it checks the word just before and just after each critical tick. A control state that is stuck or wrongly released would show as `busy` or `done` disagreeing with the tick count. It would also appear as a late request that wrongly alters the running sequence.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  localparam int CLAMP_W   = 8;
  localparam int NUM_STEPS = 5;
  localparam int STEP_W    = $clog2(NUM_STEPS);

  localparam logic [CLAMP_W-1:0] CLAMP_SHUT = 8'hFF;
  localparam logic [CLAMP_W-1:0] CLAMP_OPEN = 8'h00;

  typedef enum logic {ST_IDLE, ST_RAMP} state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadOpen;
    logic loadClose;
    logic advance;
  } strobe_t;

  // staged opening codes, index 0 first
  function automatic logic [CLAMP_W-1:0] rampCode(input logic [STEP_W-1:0] idx);
    case (idx)
      3'd0:    rampCode = 8'hFF;
      3'd1:    rampCode = 8'hFE;
      3'd2:    rampCode = 8'hF8;
      3'd3:    rampCode = 8'hF0;
      default: rampCode = CLAMP_OPEN;
    endcase
  endfunction
endpackage

// File: rtl/pcr_datapath.sv
module pcr_datapath
  import pcr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  output logic [CLAMP_W-1:0] clampWord,
  output logic               lastStep,
  output logic               clampOpen
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  logic [STEP_W-1:0]  stepQ;
  logic [STEP_W-1:0]  stepNext;
  logic [CLAMP_W-1:0] clampQ;

  assign stepNext = stepQ + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepQ  <= '0;
      clampQ <= CLAMP_SHUT;
    end else if (stb.loadClose) begin
      stepQ  <= LAST_STEP;
      clampQ <= CLAMP_SHUT;
    end else if (stb.loadOpen) begin
      stepQ  <= '0;
      clampQ <= rampCode('0);
    end else if (stb.advance && !lastStep) begin
      stepQ  <= stepNext;
      clampQ <= rampCode(stepNext);
    end
  end

  assign clampWord = clampQ;
  assign lastStep  = (stepQ == LAST_STEP);
  assign clampOpen = (clampQ == CLAMP_OPEN);

  AST_CLAMP_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (clampQ == 8'hFF) || (clampQ == 8'hFE) || (clampQ == 8'hF8) ||
    (clampQ == 8'hF0) || (clampQ == 8'h00)); // R2

  AST_ADVANCE_CHANGES: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && !lastStep) |=> (clampQ != $past(clampQ))); // R2

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (stb == '0) |=> $stable(clampQ)); // R3
endmodule

// File: rtl/pcr_ctrl.sv
module pcr_ctrl
  import pcr_pkg::*;
#(
  parameter int DWELL_TICKS = 10
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    openReq,
  input  logic    closeReq,
  input  logic    usTick,
  input  logic    lastStep,
  input  logic    clampOpen,
  output strobe_t stb,
  output logic    busy,
  output logic    done
);
  localparam int CNT_W = (DWELL_TICKS < 2) ? 1 : $clog2(DWELL_TICKS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DWELL_TICKS - 1);

  state_e          stateQ;
  logic [CNT_W-1:0] tickCnt;
  logic            isIdle;
  logic            acceptClose;
  logic            acceptOpen;
  logic            skipOpen;
  logic            stepEnd;

  always_comb begin
    isIdle      = (stateQ == ST_IDLE);
    acceptClose = isIdle && closeReq;
    acceptOpen  = isIdle && openReq && !closeReq && !clampOpen;
    skipOpen    = isIdle && openReq && !closeReq && clampOpen;
    stepEnd     = (stateQ == ST_RAMP) && usTick && (tickCnt == CNT_LAST);
    stb.loadClose = acceptClose;
    stb.loadOpen  = acceptOpen;
    stb.advance   = stepEnd && !lastStep;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      tickCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= skipOpen || (stepEnd && lastStep);
      if (acceptClose || acceptOpen) begin
        stateQ  <= ST_RAMP;
        tickCnt <= '0;
      end else if (stepEnd) begin
        tickCnt <= '0;
        if (lastStep) stateQ <= ST_IDLE;
      end else if ((stateQ == ST_RAMP) && usTick) begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  assign busy = (stateQ == ST_RAMP);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_SKIP_IMMEDIATE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && openReq && !closeReq && clampOpen) |=> (done && !busy)); // R4

  AST_CLOSE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && openReq && closeReq) |=> (busy && !done)); // R7

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !usTick) |=> (busy && !done)); // R9

  AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= CNT_LAST); // R3
endmodule

// File: rtl/pwr_clamp_ramp.sv
module pwr_clamp_ramp
  import pcr_pkg::*;
#(
  parameter int DWELL_TICKS = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               openReq,
  input  logic               closeReq,
  input  logic               usTick,
  output logic [CLAMP_W-1:0] clampWord,
  output logic               busy,
  output logic               done
);
  strobe_t stb;
  logic    lastStep;
  logic    clampOpen;

  pcr_ctrl #(.DWELL_TICKS(DWELL_TICKS)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .openReq   (openReq),
    .closeReq  (closeReq),
    .usTick    (usTick),
    .lastStep  (lastStep),
    .clampOpen (clampOpen),
    .stb       (stb),
    .busy      (busy),
    .done      (done)
  );

  pcr_datapath i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .clampWord (clampWord),
    .lastStep  (lastStep),
    .clampOpen (clampOpen)
  );
endmodule

// File: tb/test_pwr_clamp_ramp.sv
module test_pwr_clamp_ramp;
  localparam int DWELL = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       openReq = 1'b0;
  logic       closeReq = 1'b0;
  logic       usTick = 1'b0;
  logic [7:0] clampWord;
  logic       busy;
  logic       done;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  pwr_clamp_ramp #(.DWELL_TICKS(DWELL)) i_pwr_clamp_ramp (
    .clk(clk), .rstN(rstN), .openReq(openReq), .closeReq(closeReq),
    .usTick(usTick), .clampWord(clampWord), .busy(busy), .done(done)
  );

  // vector: [10:9] op (1 open, 2 close, 3 both), [8] skip expected, [7:0] final word
  localparam logic [10:0] VEC [6] = '{
    {2'd2, 1'b0, 8'hFF},   // close while shut (R5)
    {2'd1, 1'b0, 8'h00},   // staged open (R2)
    {2'd1, 1'b1, 8'h00},   // open while open: skip (R4)
    {2'd3, 1'b0, 8'hFF},   // both: close wins (R7)
    {2'd1, 1'b0, 8'h00},   // staged open again
    {2'd2, 1'b0, 8'hFF}    // close from open (R5)
  };

  function automatic logic [7:0] expCode(input int i);
    case (i)
      0: return 8'hFF;
      1: return 8'hFE;
      2: return 8'hF8;
      3: return 8'hF0;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulseTick();
    usTick = 1'b1;
    @(negedge clk);
    usTick = 1'b0;
  endtask

  // called at a negedge; injectAt >= 0 issues a late request at that step
  task automatic runOp(input logic [1:0] op, input logic skip,
                       input logic [7:0] finalExp, input int injectAt);
    int nCodes;
    openReq  = op[0];
    closeReq = op[1];
    @(negedge clk);
    openReq  = 1'b0;
    closeReq = 1'b0;
    if (skip) begin
      check("R4 done", {7'd0, done}, 8'd1);
      check("R4 busy", {7'd0, busy}, 8'd0);
      check("R4 word", clampWord, 8'h00);
      @(negedge clk);
      check("R8 done width", {7'd0, done}, 8'd0);
      check("R4 word kept", clampWord, finalExp);
      return;
    end
    nCodes = op[1] ? 1 : 5;
    for (int i = 0; i < nCodes; i++) begin
      logic [7:0] exp;
      exp = op[1] ? 8'hFF : expCode(i);
      check(op[1] ? "R5 word" : "R2 word", clampWord, exp);
      check("R9 busy", {7'd0, busy}, 8'd1);
      if (i == injectAt) begin
        openReq  = 1'b1;
        closeReq = 1'b1;
        @(negedge clk);
        openReq  = 1'b0;
        closeReq = 1'b0;
        check("R6 word unchanged", clampWord, exp);
        check("R6 still busy", {7'd0, busy}, 8'd1);
      end
      for (int k = 0; k < DWELL - 1; k++) begin
        pulseTick();
        @(negedge clk);   // idle cycle without tick
      end
      check("R3 held", clampWord, exp);
      check("R3 no done", {7'd0, done}, 8'd0);
      pulseTick();
    end
    check("R8 done", {7'd0, done}, 8'd1);
    check("R8 busy low", {7'd0, busy}, 8'd0);
    check("R5/R2 final", clampWord, finalExp);
    @(negedge clk);
    check("R8 done width", {7'd0, done}, 8'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset word", clampWord, 8'hFF);
    check("R1 reset busy", {7'd0, busy}, 8'd0);
    check("R1 reset done", {7'd0, done}, 8'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 6; v++)
      runOp(VEC[v][10:9], VEC[v][8], VEC[v][7:0], -1);

    // late request during an open ramp is ignored (R6)
    runOp(2'd1, 1'b0, 8'h00, 2);
    runOp(2'd2, 1'b0, 8'hFF, 0);

    // reset in the middle of a ramp (R1)
    openReq = 1'b1;
    @(negedge clk);
    openReq = 1'b0;
    pulseTick();
    pulseTick();
    pulseTick();
    check("R2 mid ramp", clampWord, 8'hFE);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 mid reset word", clampWord, 8'hFF);
    check("R1 mid reset busy", {7'd0, busy}, 8'd0);
    rstN = 1'b1;
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule